// File: doc/BRIEF.md
# Nested Three-Level Vectored Interrupt Arbiter

This block sits between a set of interrupt request lines and a small CPU core. Each line latches a request strobe into a pending bit. Each line is also given a priority level, taken from one select bit per line. The block picks one winner among the pending lines: the highest level wins, and among lines of equal level the lowest line index wins. It offers the CPU the fixed vector address of that winner. Mapping several peripheral sources onto one line is done outside this block, as a plain OR in front of `req_i`.

The block also tracks the levels that are currently in service, one bit for each level. A running handler can only be pre-empted by a request at a strictly higher level. An accepted request raises the in-service bit of its level. A return from interrupt drops the highest in-service bit, so the previous, lower level becomes current again.

`irq_o` and `ack_i` are plain control pins and not a stream handshake. `vec_o` always follows the current winner. The CPU takes a vector by raising `ack_i` in a cycle where `irq_o` is high. Until that happens, the offered vector may be replaced by a newly pending request that ranks higher.

Top module: `nia_top`

## Requirements
- R1: After reset no line is pending, no level is in service and `irq_o` is low.
- R2: `vec_o` for a winning line with index i (0 to 9) equals 0x0003 + 8*i, so line 0 gives 0x0003, line 4 gives 0x0023 and line 9 gives 0x004B.
- R3: The levels are ordered top (3) above high (2) above low (1). Lines 0 and 1 take top when their `lvl_sel_i` bit is 1 and low when it is 0. Lines 2 to 9 take high when their bit is 1 and low when it is 0.
- R4: Among pending lines, the line with the highest level wins. Among lines of equal level, the lowest index wins.
- R5: `irq_o` is high only when the winner's level is strictly above the highest level in service. A pending request at a level equal to or below the level in service is held off.
- R6: A one-cycle high on `req_i[i]` makes line i pending. The line stays pending until it is accepted, even while it is refused or masked. An acceptance clears only the winning line. A new strobe on that line in the same cycle leaves it pending.
- R7: `ack_i` while `irq_o` is high sets the in-service bit of the winner's level. `ack_i` while `irq_o` is low changes nothing.
- R8: `ret_i` clears the highest in-service bit, which makes the next lower in-service level current. `ret_i` with no level in service changes nothing.
- R9: With `en_i` low, `irq_o` stays low, but pending lines are kept and are offered once `en_i` returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 10 | Request strobes, one per line |
| lvl_sel_i | input | 10 | Level select bit per line (R3) |
| en_i | input | 1 | Global interrupt enable |
| ack_i | input | 1 | CPU accepts the offered vector |
| ret_i | input | 1 | CPU returns from the current handler |
| irq_o | output | 1 | Interrupt request to the CPU |
| vec_o | output | 16 | Vector address of the current winner |

## Verification
The bench builds the block with its default parameters: ten lines, of which the first two may take the top level, with a vector base of 3 and a step of 8. With these values the bench can reach both ends of the vector table. It can also reach a full three-deep nest (low, then high, then top), the refusal of an equal-level request at each depth, and the unwinding of that nest one return at a time. Ties are exercised within each level.

// File: rtl/nia_pkg.sv
package nia_pkg;
  // Level encoding: 0 means no request, larger means more urgent.
  localparam int LVL_W    = 2;
  localparam int N_LEVELS = 3;
  localparam logic [LVL_W-1:0] LV_NONE = 2'd0;
  localparam logic [LVL_W-1:0] LV_LOW  = 2'd1;
  localparam logic [LVL_W-1:0] LV_HIGH = 2'd2;
  localparam logic [LVL_W-1:0] LV_TOP  = 2'd3;

  // One-hot in-service mask bit for a nonzero level.
  function automatic logic [N_LEVELS-1:0] lvl_mask(input logic [LVL_W-1:0] lv);
    lvl_mask = '0;
    if (lv != LV_NONE) lvl_mask[lv - 2'd1] = 1'b1;
  endfunction
endpackage

// File: rtl/nia_level_map.sv
module nia_level_map
  import nia_pkg::*;
#(
  parameter int N_LINES = 10,
  parameter int N_TOP   = 2
) (
  input  logic [N_LINES-1:0]            pend_i,
  input  logic [N_LINES-1:0]            sel_i,
  output logic [N_LINES-1:0][LVL_W-1:0] lvl_o
);
  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    if (g < N_TOP) begin : g_top_capable
      assign lvl_o[g] = !pend_i[g] ? LV_NONE : (sel_i[g] ? LV_TOP : LV_LOW);
    end else begin : g_high_capable
      assign lvl_o[g] = !pend_i[g] ? LV_NONE : (sel_i[g] ? LV_HIGH : LV_LOW);
    end
  end
endmodule

// File: rtl/nia_pick.sv
module nia_pick
  import nia_pkg::*;
#(
  parameter int N_LINES = 10,
  localparam int IDX_W  = $clog2(N_LINES)
) (
  input  logic [N_LINES-1:0][LVL_W-1:0] lvl_i,
  output logic [LVL_W-1:0]              win_lvl_o,
  output logic [IDX_W-1:0]              win_idx_o
);
  // Scan from the highest index down; ">=" lets a lower index take a tie.
  always_comb begin
    win_lvl_o = LV_NONE;
    win_idx_o = '0;
    for (int i = N_LINES - 1; i >= 0; i--) begin
      if (lvl_i[i] >= win_lvl_o) begin
        win_lvl_o = lvl_i[i];
        win_idx_o = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/nia_pend.sv
module nia_pend #(
  parameter int N_LINES = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] set_i,
  input  logic [N_LINES-1:0] clr_i,
  output logic [N_LINES-1:0] pend_o
);
  logic [N_LINES-1:0] pend_q;

  // A strobe in the same cycle as a clear wins, so nothing is lost.
  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~clr_i) | set_i;
  end

  assign pend_o = pend_q;

  // R6
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(pend_q) & ~$past(clr_i)) & ~pend_q) == '0));
endmodule

// File: rtl/nia_inservice.sv
module nia_inservice
  import nia_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take_i,
  input  logic [LVL_W-1:0] take_lvl_i,
  input  logic             ret_i,
  output logic [LVL_W-1:0] cur_lvl_o
);
  logic [N_LEVELS-1:0] isr_q;
  logic [N_LEVELS-1:0] top_bit;
  logic [N_LEVELS-1:0] set_bits;

  always_comb begin
    top_bit   = '0;
    cur_lvl_o = LV_NONE;
    for (int l = 0; l < N_LEVELS; l++) begin
      if (isr_q[l]) begin
        top_bit   = '0;
        top_bit[l] = 1'b1;
        cur_lvl_o = LVL_W'(l + 1);
      end
    end
  end

  assign set_bits = take_i ? lvl_mask(take_lvl_i) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) isr_q <= '0;
    else        isr_q <= (isr_q & ~(ret_i ? top_bit : '0)) | set_bits;
  end

  // R7
  take_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && !ret_i) |=> ((isr_q & lvl_mask($past(take_lvl_i))) != '0));

  // R8
  ret_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_i && !take_i && isr_q != '0) |=>
      ($countones(isr_q) == $countones($past(isr_q)) - 1));

  // R8
  ret_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_i && !take_i && isr_q == '0) |=> (isr_q == '0));
endmodule

// File: rtl/nia_top.sv
module nia_top
  import nia_pkg::*;
#(
  parameter int N_LINES  = 10,
  parameter int N_TOP    = 2,
  parameter int VEC_W    = 16,
  parameter int VEC_BASE = 3,
  parameter int VEC_STEP = 8,
  localparam int IDX_W   = $clog2(N_LINES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] req_i,
  input  logic [N_LINES-1:0] lvl_sel_i,
  input  logic               en_i,
  input  logic               ack_i,
  input  logic               ret_i,
  output logic               irq_o,
  output logic [VEC_W-1:0]   vec_o
);
  logic [N_LINES-1:0]            pend_q;
  logic [N_LINES-1:0]            clr_mask;
  logic [N_LINES-1:0][LVL_W-1:0] line_lvl;
  logic [LVL_W-1:0]              win_lvl;
  logic [IDX_W-1:0]              win_idx;
  logic [LVL_W-1:0]              cur_lvl;
  logic                          take;

  nia_pend #(.N_LINES(N_LINES)) u_pend (
    .clk(clk), .rst_n(rst_n), .set_i(req_i), .clr_i(clr_mask), .pend_o(pend_q)
  );

  nia_level_map #(.N_LINES(N_LINES), .N_TOP(N_TOP)) u_map (
    .pend_i(pend_q), .sel_i(lvl_sel_i), .lvl_o(line_lvl)
  );

  nia_pick #(.N_LINES(N_LINES)) u_pick (
    .lvl_i(line_lvl), .win_lvl_o(win_lvl), .win_idx_o(win_idx)
  );

  nia_inservice u_isr (
    .clk(clk), .rst_n(rst_n), .take_i(take), .take_lvl_i(win_lvl),
    .ret_i(ret_i), .cur_lvl_o(cur_lvl)
  );

  assign irq_o    = en_i && (win_lvl > cur_lvl);
  assign take     = ack_i && irq_o;
  assign clr_mask = take ? (N_LINES'(1) << win_idx) : '0;
  assign vec_o    = VEC_W'(VEC_BASE) + VEC_W'(win_idx) * VEC_W'(VEC_STEP);

  // R9
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |-> !irq_o);

  // R5
  nest_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && ack_i && !ret_i) |=> (cur_lvl > $past(cur_lvl)));

  // R4
  winner_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> pend_q[win_idx]);

  // R6
  clr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(clr_mask));
endmodule

// File: tb/nia_top_test.sv
module nia_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  req = '0;
  logic [9:0]  sel = '0;
  logic        en = 1'b1;
  logic        ack = 1'b0;
  logic        ret = 1'b0;
  logic        irq;
  logic [15:0] vec;
  int          total = 0;
  int          bad = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  nia_top uut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .lvl_sel_i(sel), .en_i(en),
    .ack_i(ack), .ret_i(ret), .irq_o(irq), .vec_o(vec)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    #1;
  endtask

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic reset_all();
    rst_n = 1'b0; req = '0; sel = '0; en = 1'b1; ack = 1'b0; ret = 1'b0;
    tick(); tick();
    rst_n = 1'b1;
    #1;
  endtask

  task automatic strobe(input logic [9:0] m);
    req = m; tick(); req = '0; #1;
  endtask

  task automatic do_ack();
    ack = 1'b1; tick(); ack = 1'b0; #1;
  endtask

  task automatic do_ret();
    ret = 1'b1; tick(); ret = 1'b0; #1;
  endtask

  task automatic t_reset();
    reset_all();
    check("R1 irq after reset", 16'(irq), 16'd0);
  endtask

  task automatic t_vectors();
    reset_all();
    strobe(10'b00_0001_0000);
    check("R2 irq line4", 16'(irq), 16'd1);
    check("R2 vec line4", vec, 16'h0023);
    reset_all();
    strobe(10'b10_0000_0000);
    check("R2 vec line9", vec, 16'h004B);
    reset_all();
    strobe(10'b00_0000_0001);
    check("R2 vec line0", vec, 16'h0003);
  endtask

  task automatic t_tie_and_clear();
    reset_all();
    strobe(10'b00_1000_1000);
    check("R4 low tie lowest index", vec, 16'h001B);
    do_ack();
    check("R5 equal level refused", 16'(irq), 16'd0);
    do_ret();
    check("R6 other line kept irq", 16'(irq), 16'd1);
    check("R6 other line kept vec", vec, 16'h003B);
  endtask

  task automatic t_levels();
    reset_all();
    sel = 10'b01_0000_0000;
    strobe(10'b01_0000_0100);
    check("R3 high beats low", vec, 16'h0043);
    reset_all();
    sel = 10'b10_0000_0010;
    strobe(10'b10_0000_0011);
    check("R3 top beats high", vec, 16'h000B);
    reset_all();
    sel = 10'b00_0000_0011;
    strobe(10'b00_0000_0011);
    check("R4 top tie lowest index", vec, 16'h0003);
    reset_all();
    sel = 10'b00_0000_0100;
    strobe(10'b00_0000_0101);
    check("R3 line2 bit set is high only", vec, 16'h0013);
    do_ack();
    check("R3 line0 low below high", 16'(irq), 16'd0);
  endtask

  task automatic t_nest();
    reset_all();
    sel = 10'b00_0010_0011;
    strobe(10'b00_0000_1000);
    do_ack();
    strobe(10'b00_0100_0000);
    check("R5 low under low refused", 16'(irq), 16'd0);
    strobe(10'b00_0010_0000);
    check("R5 high over low irq", 16'(irq), 16'd1);
    check("R5 high over low vec", vec, 16'h002B);
    do_ack();
    check("R5 low under high refused", 16'(irq), 16'd0);
    strobe(10'b00_0000_0001);
    check("R5 top over high vec", vec, 16'h0003);
    do_ack();
    strobe(10'b00_0000_0010);
    check("R5 top under top refused", 16'(irq), 16'd0);
    do_ret();
    check("R8 return to high irq", 16'(irq), 16'd1);
    check("R8 return to high vec", vec, 16'h000B);
    do_ack();
    do_ret();
    do_ret();
    check("R8 back at low refuses low", 16'(irq), 16'd0);
    do_ret();
    check("R6 held request irq", 16'(irq), 16'd1);
    check("R6 held request vec", vec, 16'h0033);
  endtask

  task automatic t_ret_empty();
    reset_all();
    do_ret();
    do_ret();
    check("R8 empty return no irq", 16'(irq), 16'd0);
    strobe(10'b00_0001_0000);
    do_ack();
    strobe(10'b01_0000_0000);
    check("R8 single level after empty returns", 16'(irq), 16'd0);
    do_ret();
    check("R8 one return empties", 16'(irq), 16'd1);
  endtask

  task automatic t_enable();
    reset_all();
    en = 1'b0;
    strobe(10'b00_0000_0100);
    check("R9 masked irq", 16'(irq), 16'd0);
    tick();
    en = 1'b1; #1;
    check("R9 unmask irq", 16'(irq), 16'd1);
    check("R9 unmask vec", vec, 16'h0013);
  endtask

  task automatic t_ack_ignored();
    reset_all();
    do_ack();
    strobe(10'b00_0001_0000);
    check("R7 idle ack sets nothing", 16'(irq), 16'd1);
    reset_all();
    en = 1'b0;
    strobe(10'b00_0001_0000);
    do_ack();
    en = 1'b1; #1;
    check("R7 masked ack keeps pending", 16'(irq), 16'd1);
    check("R7 masked ack keeps vec", vec, 16'h0023);
  endtask

  task automatic t_same_cycle();
    reset_all();
    strobe(10'b00_0001_0000);
    req = 10'b00_0001_0000; ack = 1'b1;
    tick();
    req = '0; ack = 1'b0; #1;
    check("R6 restrobe refused while in service", 16'(irq), 16'd0);
    do_ret();
    check("R6 restrobe kept irq", 16'(irq), 16'd1);
    check("R6 restrobe kept vec", vec, 16'h0023);
    do_ack();
    check("R6 cleared after ack", 16'(irq), 16'd0);
    do_ret();
    check("R6 nothing left", 16'(irq), 16'd0);
  endtask

  initial begin
    t_reset();
    t_vectors();
    t_tie_and_clear();
    t_levels();
    t_nest();
    t_ret_empty();
    t_enable();
    t_ack_ignored();
    t_same_cycle();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule